// File: doc/BRIEF.md
# Snoop Invalidation and Intervention Controller

This block sits beside a private, direct-mapped, write-back cache. It watches the address cycles that other masters put on a shared system bus, such as other processors or DMA engines. It keeps a second copy of the cache's tag and state bits, so every observed cycle can be looked up without using the primary tag array that the CPU depends on. The main cache reports every fill, eviction and dirty-marking as it happens, and the controller mirrors each one into its duplicate copy in the same clock edge.

When another master writes a line the cache holds, the controller drops the line from the duplicate tags and queues an invalidate request for the main cache. The queue holds four requests. When another master reads a line the cache holds modified, the controller raises an intervention request in the cycle the bus cycle is accepted, so the memory controller does not answer with stale data. It then reads the line out of the cache's data array and places the four words on the bus in consecutive cycles. Finally it reports the line as clean, and the duplicate copy marks it clean at the same time.

The snooped bus cycle arrives on a valid/ready stream. A cycle is taken on any edge where `snp_valid` and `snp_ready` are both high, and the bus master must hold it until then. The invalidate queue leaves on a second valid/ready stream. Its head entry stays stable until `inv_ready` accepts it.

Top module: `snoop_ctrl`

## Requirements
- R1: After reset, no line is held in the duplicate tags, `snp_ready` is high, and `inv_valid`, `itv_valid` and `itv_req` are low.
- R2: A snooped address splits into a line index, `addr[7:4]`, and a tag, `addr[31:8]`, with the defaults. It hits when that index is valid and its stored tag is equal to the address tag.
- R3: An accepted write that hits queues the line index for invalidation, where it appears on `inv_index` the cycle after acceptance. It also drops the line, so a repeated write to the same address queues nothing.
- R4: An accepted read or write that misses produces no intervention and queues nothing.
- R5: An accepted read that hits a valid, clean line produces no intervention and queues nothing.
- R6: An accepted read that hits a dirty line raises `itv_req` in the acceptance cycle. Starting the next cycle, `itv_valid` is high for four consecutive cycles. In those cycles `line_rd_word` counts 0,1,2,3, `line_rd_index` holds the line index, `itv_data` equals `line_rd_data`, and `itv_last` is high only on word 3.
- R7: On the last word, `clean_valid` pulses with `clean_index` set to the line. The duplicate copy becomes clean, so a later read of the line causes no intervention.
- R8: The invalidate queue holds 4 entries. `snp_ready` drops when it is full, and a bus cycle presented then is not taken. Outside an intervention, this is the only reason `snp_ready` goes low.
- R9: `snp_ready` is low for all cycles in which `itv_valid` is high.
- R10: The `upd_op` code sets the effect of an update: 0 fills the line (valid, clean, new tag), 1 evicts it (not valid), and 2 marks it dirty. An update takes effect at the next edge. When an update and a snoop effect target the same index in one cycle, the update wins.
- R11: While `inv_valid` is high and `inv_ready` is low, `inv_valid` stays high and `inv_index` stays stable. Entries leave the queue in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped bus cycle present |
| snp_ready | output | 1 | Controller can take the bus cycle |
| snp_write | input | 1 | Snooped cycle is a write (1) or read (0) |
| snp_addr | input | ADDR_W | Snooped byte address |
| itv_req | output | 1 | Intervention claimed for the cycle being accepted |
| itv_valid | output | 1 | Intervention data word present |
| itv_data | output | DATA_W | Intervention data word |
| itv_last | output | 1 | Final word of the line |
| line_rd_index | output | IDX_W | Line index to read from the cache data array |
| line_rd_word | output | WORD_W | Word within the line to read |
| line_rd_data | input | DATA_W | Data-array word at the addressed location (same cycle) |
| clean_valid | output | 1 | Line has been written out and is now clean |
| clean_index | output | IDX_W | Index of the line now clean |
| upd_valid | input | 1 | Main cache tag change this cycle |
| upd_op | input | 2 | 0 fill, 1 evict, 2 mark dirty |
| upd_index | input | IDX_W | Line index changed |
| upd_tag | input | TAG_W | Tag written on fill |
| inv_valid | output | 1 | Invalidate request available |
| inv_ready | input | 1 | Main cache takes the invalidate request |
| inv_index | output | IDX_W | Line index to invalidate |

## Verification
On every cycle, the assertions check the shape of an intervention burst: it starts after an accepted request, its word count steps by one, its index holds, it ends after the last word, and a clean report comes with that last word. They also check that the bus is refused only during a burst or with a full queue, and that a stalled invalidate request holds steady. The effect of a lookup depends on the duplicate tag contents, and only the bench's scenarios can show it. Those scenarios cover miss against hit, clean against dirty, a dropped line after a write, a cleaned line after intervention, eviction, and the priority of a same-cycle update over a snoop invalidation. The same holds for the drain order of the queue and for a stalled cycle never being taken.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    UPD_FILL  = 2'd0,
    UPD_EVICT = 2'd1,
    UPD_DIRTY = 2'd2
  } upd_op_e;
endpackage

// File: rtl/snoop_tag_dup.sv
module snoop_tag_dup
  import snoop_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_index,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_dirty,
  input  logic             upd_valid,
  input  upd_op_e          upd_op,
  input  logic [IDX_W-1:0] upd_index,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_index,
  input  logic             cln_en,
  input  logic [IDX_W-1:0] cln_index
);
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  drt_q;
  logic [TAG_W-1:0] tag_q [SETS];

  // Lookup sees the state before any write of this cycle.
  assign lk_hit   = vld_q[lk_index] && (tag_q[lk_index] == lk_tag);
  assign lk_dirty = drt_q[lk_index];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
      for (int i = 0; i < SETS; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < SETS; i++) begin
        if (upd_valid && upd_index == IDX_W'(i)) begin
          // Main-cache changes take priority over snoop effects.
          unique case (upd_op)
            UPD_FILL: begin
              vld_q[i] <= 1'b1;
              drt_q[i] <= 1'b0;
              tag_q[i] <= upd_tag;
            end
            UPD_EVICT: begin
              vld_q[i] <= 1'b0;
              drt_q[i] <= 1'b0;
            end
            UPD_DIRTY: drt_q[i] <= 1'b1;
            default: ;
          endcase
        end else begin
          if (drop_en && drop_index == IDX_W'(i)) begin
            vld_q[i] <= 1'b0;
            drt_q[i] <= 1'b0;
          end
          if (cln_en && cln_index == IDX_W'(i)) drt_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/snoop_inv_fifo.sv
module snoop_inv_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign dout      = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= din;
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_itv_seq.sv
module snoop_itv_seq #(
  parameter int IDX_W      = 4,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_index,
  output logic              busy,
  output logic              last,
  output logic [IDX_W-1:0]  index,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);

  assign last = busy && (word == LAST_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      word  <= '0;
      index <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      word  <= '0;
      index <= start_index;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      word <= word + 1'b1;
    end
  end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int INV_DEPTH  = 4,
  localparam int WORD_W    = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = WORD_W + $clog2(DATA_W / 8),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              itv_req,
  output logic              itv_valid,
  output logic [DATA_W-1:0] itv_data,
  output logic              itv_last,
  output logic [IDX_W-1:0]  line_rd_index,
  output logic [WORD_W-1:0] line_rd_word,
  input  logic [DATA_W-1:0] line_rd_data,
  output logic              clean_valid,
  output logic [IDX_W-1:0]  clean_index,
  input  logic              upd_valid,
  input  logic [1:0]        upd_op,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic [TAG_W-1:0]  upd_tag,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [IDX_W-1:0]  inv_index
);
  logic [IDX_W-1:0] lk_index;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit, lk_dirty;
  logic             accept, q_full, q_push, itv_start;
  logic             seq_busy, seq_last;

  assign lk_index = snp_addr[OFF_W +: IDX_W];
  assign lk_tag   = snp_addr[ADDR_W-1 -: TAG_W];

  assign snp_ready = !seq_busy && !q_full;
  assign accept    = snp_valid && snp_ready;
  assign q_push    = accept && snp_write && lk_hit;
  assign itv_start = accept && !snp_write && lk_hit && lk_dirty;
  assign itv_req   = itv_start;

  snoop_tag_dup #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_index   (lk_index),
    .lk_tag     (lk_tag),
    .lk_hit     (lk_hit),
    .lk_dirty   (lk_dirty),
    .upd_valid  (upd_valid),
    .upd_op     (upd_op_e'(upd_op)),
    .upd_index  (upd_index),
    .upd_tag    (upd_tag),
    .drop_en    (q_push),
    .drop_index (lk_index),
    .cln_en     (seq_last),
    .cln_index  (line_rd_index)
  );

  snoop_inv_fifo #(.W(IDX_W), .DEPTH(INV_DEPTH)) u_invq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .din       (lk_index),
    .full      (q_full),
    .out_valid (inv_valid),
    .out_ready (inv_ready),
    .dout      (inv_index)
  );

  snoop_itv_seq #(.IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (itv_start),
    .start_index (lk_index),
    .busy        (seq_busy),
    .last        (seq_last),
    .index       (line_rd_index),
    .word        (line_rd_word)
  );

  assign itv_valid   = seq_busy;
  assign itv_last    = seq_last;
  assign itv_data    = line_rd_data;
  assign clean_valid = seq_last;
  assign clean_index = line_rd_index;
endmodule

// File: rtl/snoop_ctrl_chk.sv
module snoop_ctrl_chk #(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snp_valid,
  input logic              snp_ready,
  input logic              snp_write,
  input logic              itv_req,
  input logic              itv_valid,
  input logic              itv_last,
  input logic [WORD_W-1:0] line_rd_word,
  input logic [IDX_W-1:0]  line_rd_index,
  input logic              clean_valid,
  input logic [IDX_W-1:0]  clean_index,
  input logic              inv_valid,
  input logic              inv_ready,
  input logic [IDX_W-1:0]  inv_index
);
  AST_REQ_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    itv_req |-> snp_valid && !snp_write); // R6
  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_ready && itv_req |=> itv_valid && line_rd_word == '0); // R6
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    itv_valid && !itv_last |=> itv_valid && line_rd_word == WORD_W'($past(line_rd_word) + 1'b1)); // R6
  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    itv_valid && !itv_last |=> $stable(line_rd_index)); // R6
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    itv_valid && itv_last |=> !itv_valid); // R6
  AST_CLEAN_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    itv_valid && itv_last |-> clean_valid && clean_index == line_rd_index); // R7
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_ready && !itv_valid |-> inv_valid); // R8
  AST_NO_ACCEPT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    itv_valid |-> !snp_ready); // R9
  AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_index)); // R11
endmodule

bind snoop_ctrl snoop_ctrl_chk #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .snp_valid     (snp_valid),
  .snp_ready     (snp_ready),
  .snp_write     (snp_write),
  .itv_req       (itv_req),
  .itv_valid     (itv_valid),
  .itv_last      (itv_last),
  .line_rd_word  (line_rd_word),
  .line_rd_index (line_rd_index),
  .clean_valid   (clean_valid),
  .clean_index   (clean_index),
  .inv_valid     (inv_valid),
  .inv_ready     (inv_ready),
  .inv_index     (inv_index)
);

// File: tb/snoop_ctrl_tb.sv
module snoop_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snp_valid = 1'b0, snp_write = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        snp_ready, itv_req, itv_valid, itv_last, clean_valid, inv_valid;
  logic [31:0] itv_data, line_rd_data;
  logic [3:0]  line_rd_index, clean_index, inv_index;
  logic [1:0]  line_rd_word;
  logic        upd_valid = 1'b0, inv_ready = 1'b1;
  logic [1:0]  upd_op = '0;
  logic [3:0]  upd_index = '0;
  logic [23:0] upd_tag = '0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] line_word(logic [3:0] idx, logic [1:0] w);
    return 32'hC0DE_0000 | (32'(idx) << 8) | 32'(w);
  endfunction
  assign line_rd_data = line_word(line_rd_index, line_rd_word);

  snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_ready(snp_ready),
    .snp_write(snp_write), .snp_addr(snp_addr), .itv_req(itv_req),
    .itv_valid(itv_valid), .itv_data(itv_data), .itv_last(itv_last),
    .line_rd_index(line_rd_index), .line_rd_word(line_rd_word),
    .line_rd_data(line_rd_data), .clean_valid(clean_valid),
    .clean_index(clean_index), .upd_valid(upd_valid), .upd_op(upd_op),
    .upd_index(upd_index), .upd_tag(upd_tag), .inv_valid(inv_valid),
    .inv_ready(inv_ready), .inv_index(inv_index)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_upd(input logic [1:0] op, input logic [31:0] addr);
    @(negedge clk);
    upd_valid = 1'b1; upd_op = op; upd_index = addr[7:4]; upd_tag = addr[31:8];
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_snoop(input logic wr, input logic [31:0] addr,
                          input logic exp_inv, input logic exp_itv, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_write = wr; snp_addr = addr; #1;
    check(snp_ready == 1'b1, {req, " ready"}, 32'(snp_ready), 1);
    check(itv_req == exp_itv, {req, " itv_req"}, 32'(itv_req), 32'(exp_itv));
    @(negedge clk);
    snp_valid = 1'b0; #1;
    check(inv_valid == exp_inv, {req, " inv_valid"}, 32'(inv_valid), 32'(exp_inv));
    if (exp_inv) check(inv_index == addr[7:4], {req, " inv_index"}, 32'(inv_index), 32'(addr[7:4]));
    if (exp_itv) begin
      for (int w = 0; w < 4; w++) begin
        check(itv_valid && line_rd_word == 2'(w) && line_rd_index == addr[7:4],
              "R6 burst word", {itv_valid, 26'(line_rd_index), 2'(line_rd_word)},
              {1'b1, 26'(addr[7:4]), 2'(w)});
        check(itv_data == line_word(addr[7:4], 2'(w)), "R6 data", itv_data, line_word(addr[7:4], 2'(w)));
        check(itv_last == (w == 3), "R6 last", 32'(itv_last), 32'(w == 3));
        check(clean_valid == (w == 3), "R7 clean pulse", 32'(clean_valid), 32'(w == 3));
        check(snp_ready == 1'b0, "R9 stalled in burst", 32'(snp_ready), 0);
        if (w < 3) begin @(negedge clk); #1; end
      end
      check(clean_index == addr[7:4], "R7 clean_index", 32'(clean_index), 32'(addr[7:4]));
      @(negedge clk); #1;
      check(itv_valid == 1'b0, "R6 burst ended", 32'(itv_valid), 0);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 fill, 1 evict, 2 dirty, 3 snoop
    logic        wr;
    logic [31:0] addr;
    logic        exp_inv;
    logic        exp_itv;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{2'd0, 1'b0, 32'h0000_AB10, 1'b0, 1'b0},
    '{2'd3, 1'b0, 32'h0000_AB10, 1'b0, 1'b0},  // R5 clean read hit
    '{2'd3, 1'b0, 32'h0000_AC10, 1'b0, 1'b0},  // R4 read miss (tag differs)
    '{2'd3, 1'b1, 32'h0000_AC10, 1'b0, 1'b0},  // R4 write miss
    '{2'd2, 1'b0, 32'h0000_AB10, 1'b0, 1'b0},
    '{2'd3, 1'b0, 32'h0000_AB14, 1'b0, 1'b1},  // R6 dirty read hit, R2 offset ignored
    '{2'd3, 1'b0, 32'h0000_AB10, 1'b0, 1'b0},  // R7 now clean
    '{2'd3, 1'b1, 32'h0000_AB18, 1'b1, 1'b0},  // R3 write hit
    '{2'd3, 1'b1, 32'h0000_AB10, 1'b0, 1'b0},  // R3 line dropped
    '{2'd0, 1'b0, 32'h1234_5670, 1'b0, 1'b0},
    '{2'd2, 1'b0, 32'h1234_5670, 1'b0, 1'b0},
    '{2'd1, 1'b0, 32'h1234_5670, 1'b0, 1'b0},
    '{2'd3, 1'b0, 32'h1234_5670, 1'b0, 1'b0},  // R10 evicted line misses
    '{2'd0, 1'b0, 32'h1234_5670, 1'b0, 1'b0},
    '{2'd3, 1'b1, 32'h1234_567C, 1'b1, 1'b0}   // R10 refill hits, R3
  };

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1 reset state
    check(snp_ready == 1'b1, "R1 ready", 32'(snp_ready), 1);
    check(inv_valid == 1'b0, "R1 inv_valid", 32'(inv_valid), 0);
    check(itv_valid == 1'b0, "R1 itv_valid", 32'(itv_valid), 0);
    do_snoop(1'b1, 32'h0000_0000, 1'b0, 1'b0, "R1 empty write");
    do_snoop(1'b0, 32'h0000_0000, 1'b0, 1'b0, "R1 empty read");

    for (int i = 0; i < 15; i++) begin
      if (VEC[i].kind != 2'd3) do_upd(VEC[i].kind, VEC[i].addr);
      else do_snoop(VEC[i].wr, VEC[i].addr, VEC[i].exp_inv, VEC[i].exp_itv, "R2 R3 R4 R5 vec");
    end

    // R8/R11: fill queue with inv_ready low
    for (int k = 2; k < 6; k++) do_upd(2'd0, {24'h000001, 4'(k), 4'h0});
    do_upd(2'd0, 32'h0000_0180);
    @(negedge clk); inv_ready = 1'b0;
    for (int k = 2; k < 6; k++) begin
      @(negedge clk);
      snp_valid = 1'b1; snp_write = 1'b1; snp_addr = {24'h000001, 4'(k), 4'h0};
      @(negedge clk);
      snp_valid = 1'b0; #1;
      check(inv_valid && inv_index == 4'd2, "R11 head held", 32'(inv_index), 2);
    end
    check(snp_ready == 1'b0, "R8 ready low when full", 32'(snp_ready), 0);
    snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 32'h0000_0180;
    repeat (2) @(negedge clk);
    snp_valid = 1'b0; #1;
    check(snp_ready == 1'b0, "R8 still full", 32'(snp_ready), 0);
    inv_ready = 1'b1;
    for (int k = 2; k < 6; k++) begin
      check(inv_valid && inv_index == 4'(k), "R11 drain order", 32'(inv_index), k);
      @(negedge clk); #1;
    end
    check(inv_valid == 1'b0, "R8 stalled cycle not taken", 32'(inv_valid), 0);
    do_snoop(1'b1, 32'h0000_0180, 1'b1, 1'b0, "R8 line 8 still held");

    // R10 update wins over same-cycle snoop invalidate
    do_upd(2'd0, 32'h0000_0660);
    @(negedge clk);
    snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 32'h0000_0660;
    upd_valid = 1'b1; upd_op = 2'd2; upd_index = 4'd6;
    @(negedge clk);
    snp_valid = 1'b0; upd_valid = 1'b0; #1;
    check(inv_valid && inv_index == 4'd6, "R3 priority case queued", 32'(inv_index), 6);
    @(negedge clk);
    do_snoop(1'b0, 32'h0000_0660, 1'b0, 1'b1, "R10 update wins");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule